// File: doc/BRIEF.md
# Merging Write Buffer with Conflict-Checked Read Bypass

This block sits between a cache and the next memory level. Each write that the cache hands over is held here and sent out to memory in the background, so the processor is not stalled by slow stores. A write to a block that already has a waiting entry is folded into that entry under a per-word mask. Dirty victims are parked through the same write port.

A read miss uses a single memory port together with the drains. When the read's block address matches no buffered entry, and matches no write presented in the same cycle, the read goes out at the next request boundary, ahead of older writes. When the address does match, the read waits until every matching entry has been written to memory. A request already on the memory port stays there until memory accepts it, and only then is the next request chosen. When a victim write and a read miss arrive together, the read is issued first and the victim is written back afterwards.

Storage is a ring of `DEPTH` entries. Each entry holds one block of `WORDS` words of `DATA_W` bits, a block address, a valid bit and a word mask. Entries drain strictly oldest-first.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset `mem_valid` is low and both `wr_ready` and `rd_ready` are high.
- R2: An accepted write leaves as a memory write (`mem_write`=1) with its block address, its word mask and its data. Bit i of `mem_mask` marks word i, carried at `mem_line[i*DATA_W +: DATA_W]`. The entry is freed on the cycle `mem_valid` and `mem_ready` are both high.
- R3: A write whose address equals that of a valid entry not currently on the memory port merges into it. The mask becomes the OR of both masks, and the newer words replace the older ones.
- R4: A write whose address matches only the entry currently being drained takes a new entry, and both entries are written in acceptance order.
- R5: Entries are written to memory oldest-first.
- R6: When all entries are occupied and an incoming write does not merge, `wr_ready` is low until an entry drains.
- R7: A read whose address matches no valid entry and no same-cycle write is issued (`mem_write`=0) at the next boundary, ahead of older buffered writes.
- R8: A read whose address matches a valid entry, or a write presented in the same cycle, is held with `rd_ready` low until those entries are written. It is then issued.
- R9: A request on the memory port holds its fields until `mem_ready`. While a request is outstanding, `rd_ready` is low.
- R10: A victim write and a read to a different block presented in the same cycle give a memory read first, followed by the victim write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Write request from the cache |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | ADDR_W | Block address of the write |
| wr_mask | input | WORDS | Words carried by the write |
| wr_line | input | WORDS*DATA_W | Write data, word i at bits i*DATA_W |
| rd_valid | input | 1 | Read miss request |
| rd_ready | output | 1 | Read accepted and forwarded to memory |
| rd_addr | input | ADDR_W | Block address of the read |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 = write drain, 0 = read |
| mem_addr | output | ADDR_W | Request block address |
| mem_mask | output | WORDS | Word mask of a write, zero for a read |
| mem_line | output | WORDS*DATA_W | Write data, zero for a read |

## Verification
Two events can fall on the same clock edge: parking a victim line and issuing a read miss. Scenario tasks present both on one cycle, once with different block addresses and once with the same address. The order of requests on the memory port is then judged: read before victim in the first case, and victim before read in the second. A second pair is a merge racing a drain. While the oldest entry is on the port, a write to that same block is sent, and the bench expects two separate drains with the original and the new words.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // Kind of request on the memory port; the encoding is visible as mem_write.
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mem_op_e;
endpackage

// File: rtl/wbuf_match.sv
// Associative compare of one key against every entry address.
module wbuf_match #(
  parameter int ADDR_W = 27,
  parameter int DEPTH  = 4
) (
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0]            key_i,
  output logic [DEPTH-1:0]             hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (addr_i[g] == key_i);
  end
endmodule

// File: rtl/wbuf_slot.sv
// One buffered block: valid bit, address, word mask, data.
module wbuf_slot #(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORDS-1:0]  mask_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORDS-1:0]  mask_o,
  output logic [LINE_W-1:0] line_o
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORDS-1:0]  mask_q, mask_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              data_en;

  assign data_en = alloc_i || merge_i;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    mask_d  = mask_q;
    line_d  = line_q;
    if (clear_i) begin
      valid_d = 1'b0;
      mask_d  = '0;
    end
    if (alloc_i) begin
      valid_d = 1'b1;
      addr_d  = addr_i;
      mask_d  = mask_i;
      line_d  = line_i;
    end else if (merge_i) begin
      mask_d = mask_q | mask_i;
      for (int w = 0; w < WORDS; w++) begin
        if (mask_i[w]) line_d[w*DATA_W +: DATA_W] = line_i[w*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      addr_q <= addr_d;
      line_q <= line_d;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign mask_o  = mask_q;
  assign line_o  = line_q;

  // R3: a merge lands only in an occupied entry and keeps every earlier word
  p_merge_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> valid_q && !alloc_i);
  p_merge_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_i && !clear_i) |=> ((mask_q & $past(mask_i)) == $past(mask_i)) &&
                              ((mask_q & $past(mask_q)) == $past(mask_q)));
endmodule

// File: rtl/wbuf_issue.sv
// Registered memory request: holds read or drain until memory accepts.
module wbuf_issue
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_rd_i,
  input  logic              issue_wr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORDS-1:0]  wr_mask_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORDS-1:0]  mem_mask_o,
  output logic [LINE_W-1:0] mem_line_o,
  output logic              wr_done_o
);
  logic              valid_q, valid_d;
  mem_op_e           op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORDS-1:0]  mask_q, mask_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              load_en;

  assign load_en = issue_rd_i || issue_wr_i;

  always_comb begin
    valid_d = valid_q;
    op_d    = op_q;
    addr_d  = addr_q;
    mask_d  = mask_q;
    line_d  = line_q;
    if (valid_q && mem_ready_i) valid_d = 1'b0;
    if (issue_rd_i) begin
      valid_d = 1'b1;
      op_d    = OP_READ;
      addr_d  = rd_addr_i;
      mask_d  = '0;
      line_d  = '0;
    end else if (issue_wr_i) begin
      valid_d = 1'b1;
      op_d    = OP_WRITE;
      addr_d  = wr_addr_i;
      mask_d  = wr_mask_i;
      line_d  = wr_line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      op_q    <= OP_READ;
    end else begin
      valid_q <= valid_d;
      if (load_en) op_q <= op_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= addr_d;
      mask_q <= mask_d;
      line_q <= line_d;
    end
  end

  assign mem_valid_o = valid_q;
  assign mem_write_o = (op_q == OP_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_mask_o  = mask_q;
  assign mem_line_o  = line_q;
  assign wr_done_o   = valid_q && mem_ready_i && (op_q == OP_WRITE);

  // R9: an outstanding request is frozen until accepted, and nothing new is loaded over it
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !mem_ready_i) |=> valid_q && $stable(op_q) && $stable(addr_q) &&
                                  $stable(mask_q) && $stable(line_q));
  p_issue_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_rd_i || issue_wr_i) |-> !valid_q && !(issue_rd_i && issue_wr_i));
endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  parameter int DEPTH  = 4,
  localparam int LINE_W = WORDS * DATA_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORDS-1:0]  wr_mask,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORDS-1:0]  mem_mask,
  output logic [LINE_W-1:0] mem_line
);
  // Reset: asserted asynchronously, released after two clocks
  logic rst_meta_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  logic [DEPTH-1:0]             slot_valid;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][WORDS-1:0]  slot_mask;
  logic [DEPTH-1:0][LINE_W-1:0] slot_line;
  logic [DEPTH-1:0]             wr_hit, rd_hit, lock, merge_vec;
  logic [PTR_W-1:0]             head_q, head_d, tail_q, tail_d;
  logic                         wr_done, busy, inflight_wr;
  logic                         rd_conflict, issue_rd, issue_wr;
  logic                         merge_hit, wr_fire, alloc;

  wbuf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wr_match (
    .valid_i(slot_valid), .addr_i(slot_addr), .key_i(wr_addr), .hit_o(wr_hit));
  wbuf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rd_match (
    .valid_i(slot_valid), .addr_i(slot_addr), .key_i(rd_addr), .hit_o(rd_hit));

  // Arbitration at a request boundary: read first, then the oldest entry
  assign busy        = mem_valid;
  assign inflight_wr = mem_valid && mem_write;
  assign rd_conflict = (|rd_hit) || (wr_valid && (wr_addr == rd_addr));
  assign rd_ready    = !busy && !rd_conflict;
  assign issue_rd    = rd_valid && rd_ready;
  assign issue_wr    = !busy && !issue_rd && slot_valid[head_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lock
    assign lock[g] = (head_q == PTR_W'(g)) && (inflight_wr || issue_wr);
  end

  assign merge_vec = wr_hit & ~lock;
  assign merge_hit = |merge_vec;
  assign wr_ready  = merge_hit || !slot_valid[tail_q];
  assign wr_fire   = wr_valid && wr_ready;
  assign alloc     = wr_fire && !merge_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    wbuf_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_slot (
      .clk     (clk),
      .rst_n   (srst_n),
      .alloc_i (alloc && (tail_q == PTR_W'(g))),
      .merge_i (wr_fire && merge_vec[g]),
      .clear_i (wr_done && (head_q == PTR_W'(g))),
      .addr_i  (wr_addr),
      .mask_i  (wr_mask),
      .line_i  (wr_line),
      .valid_o (slot_valid[g]),
      .addr_o  (slot_addr[g]),
      .mask_o  (slot_mask[g]),
      .line_o  (slot_line[g])
    );
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (wr_done) head_d = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    if (alloc)   tail_d = (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  wbuf_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_issue (
    .clk         (clk),
    .rst_n       (srst_n),
    .issue_rd_i  (issue_rd),
    .issue_wr_i  (issue_wr),
    .rd_addr_i   (rd_addr),
    .wr_addr_i   (slot_addr[head_q]),
    .wr_mask_i   (slot_mask[head_q]),
    .wr_line_i   (slot_line[head_q]),
    .mem_ready_i (mem_ready),
    .mem_valid_o (mem_valid),
    .mem_write_o (mem_write),
    .mem_addr_o  (mem_addr),
    .mem_mask_o  (mem_mask),
    .mem_line_o  (mem_line),
    .wr_done_o   (wr_done)
  );

  // Checking aid: entries that still hold the block now on the memory port
  logic [DEPTH-1:0] port_hit;
  wbuf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_port_match (
    .valid_i(slot_valid), .addr_i(slot_addr), .key_i(mem_addr), .hit_o(port_hit));

  // R8: a newly issued read never overtakes a buffered write to its block
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(mem_valid) && !mem_write) |-> (port_hit == '0));
  // R5: a drain always carries the oldest entry
  p_drain_head_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_valid && mem_write) |-> slot_valid[head_q] && (slot_addr[head_q] == mem_addr));
  // R4: the entry on the memory port is not altered by a later write
  p_inflight_frozen_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_valid && mem_write) |-> (slot_mask[head_q] == mem_mask) &&
                                 (slot_line[head_q] == mem_line));
  // R6: no entry is overwritten while occupied
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_fire && (&slot_valid)) |-> merge_hit);
endmodule

// File: tb/merge_write_buffer_test.sv
module merge_write_buffer_test;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 27;
  localparam int DATA_W = 32;
  localparam int WORDS  = 8;
  localparam int DEPTH  = 4;
  localparam int LINE_W = WORDS * DATA_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [WORDS-1:0]  wr_mask = '0;
  logic [LINE_W-1:0] wr_line = '0;
  logic              wr_ready, rd_ready, mem_valid, mem_write;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORDS-1:0]  mem_mask;
  logic [LINE_W-1:0] mem_line;

  int checks = 0;
  int errors = 0;

  logic              log_wr   [32];
  logic [ADDR_W-1:0] log_addr [32];
  logic [WORDS-1:0]  log_mask [32];
  logic [LINE_W-1:0] log_line [32];
  int                log_n = 0;

  always #(PERIOD/2) clk = ~clk;

  merge_write_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_line(wr_line),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_mask(mem_mask), .mem_line(mem_line));

  // Memory-side recorder: a handshake seen mid-cycle completes at the next edge
  always @(negedge clk) begin
    if (mem_valid && mem_ready && log_n < 32) begin
      log_wr[log_n]   = mem_write;
      log_addr[log_n] = mem_addr;
      log_mask[log_n] = mem_mask;
      log_line[log_n] = mem_line;
      log_n = log_n + 1;
    end
  end

  function automatic logic [LINE_W-1:0] mk_line(input logic [23:0] seed);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WORDS; w++) l[w*DATA_W +: DATA_W] = {seed, 8'(w)};
    return l;
  endfunction

  function automatic logic [LINE_W-1:0] spread(input logic [WORDS-1:0] m);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WORDS; w++) l[w*DATA_W +: DATA_W] = {DATA_W{m[w]}};
    return l;
  endfunction

  task automatic chk(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [WORDS-1:0] m, input logic [LINE_W-1:0] l);
    wr_valid = 1'b1; wr_addr = a; wr_mask = m; wr_line = l;
    do @(negedge clk); while (!wr_ready);
    step();
    wr_valid = 1'b0;
  endtask

  task automatic both(input logic [ADDR_W-1:0] wa, input logic [ADDR_W-1:0] ra);
    bit wdone = 0, rdone = 0;
    wr_valid = 1'b1; wr_addr = wa; wr_mask = '1; wr_line = mk_line(24'(wa));
    rd_valid = 1'b1; rd_addr = ra;
    while (!(wdone && rdone)) begin
      bit wa_ok, ra_ok;
      @(negedge clk);
      wa_ok = wr_valid && wr_ready;
      ra_ok = rd_valid && rd_ready;
      step();
      if (wa_ok) begin wr_valid = 1'b0; wdone = 1; end
      if (ra_ok) begin rd_valid = 1'b0; rdone = 1; end
    end
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 300 && log_n < n; i++) @(negedge clk);
    step();
  endtask

  task automatic chk_entry(input string req, input int i, input logic w, input logic [ADDR_W-1:0] a,
                           input logic [WORDS-1:0] m, input logic [LINE_W-1:0] l);
    chk(req, {log_wr[i], log_addr[i]}, {w, a});
    if (w) begin
      chk(req, LINE_W'(log_mask[i]), LINE_W'(m));
      chk(req, log_line[i] & spread(m), l & spread(m));
    end
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    @(negedge clk);
    chk("R1 mem_valid", LINE_W'(mem_valid), '0);
    chk("R1 wr_ready", LINE_W'(wr_ready), 1);
    chk("R1 rd_ready", LINE_W'(rd_ready), 1);
    step();
  endtask

  task automatic t_single();
    log_n = 0; mem_ready = 1'b1;
    do_write(27'h100, 8'h05, mk_line(24'hA1));
    wait_log(1);
    chk("R2 count", log_n, 1);
    chk_entry("R2 drain", 0, 1'b1, 27'h100, 8'h05, mk_line(24'hA1));
  endtask

  task automatic t_merge_full();
    log_n = 0; mem_ready = 1'b0;
    do_write(27'h200, 8'h01, mk_line(24'hB0));
    do_write(27'h201, 8'h01, mk_line(24'hB1));
    do_write(27'h201, 8'h02, mk_line(24'hB2));
    do_write(27'h202, 8'hFF, mk_line(24'hB3));
    do_write(27'h203, 8'hFF, mk_line(24'hB4));
    wr_valid = 1'b1; wr_addr = 27'h204; wr_mask = 8'hFF; wr_line = mk_line(24'hB5);
    repeat (3) begin
      @(negedge clk);
      chk("R6 full backpressure", LINE_W'(wr_ready), '0);
    end
    step();
    mem_ready = 1'b1;
    do @(negedge clk); while (!wr_ready);
    step();
    wr_valid = 1'b0;
    wait_log(5);
    chk("R5 count", log_n, 5);
    chk_entry("R5 oldest first", 0, 1'b1, 27'h200, 8'h01, mk_line(24'hB0));
    chk_entry("R3 merged", 1, 1'b1, 27'h201, 8'h03,
              (mk_line(24'hB1) & spread(8'h01)) | (mk_line(24'hB2) & spread(8'h02)));
    chk_entry("R5 order", 2, 1'b1, 27'h202, 8'hFF, mk_line(24'hB3));
    chk_entry("R5 order", 3, 1'b1, 27'h203, 8'hFF, mk_line(24'hB4));
    chk_entry("R6 after drain", 4, 1'b1, 27'h204, 8'hFF, mk_line(24'hB5));
  endtask

  task automatic t_inflight();
    log_n = 0; mem_ready = 1'b0;
    do_write(27'h300, 8'h01, mk_line(24'hC1));
    do_write(27'h300, 8'h02, mk_line(24'hC2));
    repeat (2) step();
    mem_ready = 1'b1;
    wait_log(2);
    chk("R4 count", log_n, 2);
    chk_entry("R4 original", 0, 1'b1, 27'h300, 8'h01, mk_line(24'hC1));
    chk_entry("R4 new entry", 1, 1'b1, 27'h300, 8'h02, mk_line(24'hC2));
  endtask

  task automatic t_bypass();
    log_n = 0; mem_ready = 1'b0;
    do_write(27'h400, 8'hFF, mk_line(24'hD0));
    do_write(27'h401, 8'hFF, mk_line(24'hD1));
    rd_valid = 1'b1; rd_addr = 27'h4FF;
    @(negedge clk);
    chk("R9 read waits for drain", LINE_W'(rd_ready), '0);
    step();
    mem_ready = 1'b1;
    do @(negedge clk); while (!rd_ready);
    step();
    rd_valid = 1'b0;
    wait_log(3);
    chk_entry("R9 drain completes", 0, 1'b1, 27'h400, 8'hFF, mk_line(24'hD0));
    chk_entry("R7 read bypasses", 1, 1'b0, 27'h4FF, '0, '0);
    chk_entry("R7 write after read", 2, 1'b1, 27'h401, 8'hFF, mk_line(24'hD1));
  endtask

  task automatic t_conflict();
    log_n = 0; mem_ready = 1'b0;
    do_write(27'h500, 8'hFF, mk_line(24'hE0));
    do_write(27'h501, 8'h0F, mk_line(24'hE1));
    rd_valid = 1'b1; rd_addr = 27'h501;
    step();
    mem_ready = 1'b1;
    do @(negedge clk); while (!rd_ready);
    step();
    rd_valid = 1'b0;
    wait_log(3);
    chk_entry("R8 first drain", 0, 1'b1, 27'h500, 8'hFF, mk_line(24'hE0));
    chk_entry("R8 conflict drained", 1, 1'b1, 27'h501, 8'h0F, mk_line(24'hE1));
    chk_entry("R8 read last", 2, 1'b0, 27'h501, '0, '0);
  endtask

  task automatic t_evict();
    log_n = 0; mem_ready = 1'b1;
    both(27'h600, 27'h610);
    wait_log(2);
    chk_entry("R10 read first", 0, 1'b0, 27'h610, '0, '0);
    chk_entry("R10 victim after", 1, 1'b1, 27'h600, 8'hFF, mk_line(24'h600));
    log_n = 0;
    both(27'h700, 27'h700);
    wait_log(2);
    chk_entry("R8 same-cycle write first", 0, 1'b1, 27'h700, 8'hFF, mk_line(24'h700));
    chk_entry("R8 same-cycle read after", 1, 1'b0, 27'h700, '0, '0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_merge_full();
    t_inflight();
    t_bypass();
    t_conflict();
    t_evict();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule